// File: doc/BRIEF.md
# External Interrupt Arbiter

This block sits beside an instruction core and decides, each time the core reports an instruction boundary, whether an external interrupt starts service and which one. It accepts a level-sensitive maskable request and a non-maskable request. It holds the interrupt-enable flag, the non-maskable-in-service state and a single pending non-maskable latch. When service starts it emits a one-cycle start pulse with an 8-bit vector.

Non-maskable requests carry a fixed internal vector. Maskable requests fetch their vector through a request/acknowledge handshake. Starting any service clears the enable flag and pushes its previous value onto a small save stack. The return strobe pops that stack and also ends non-maskable service. A non-maskable edge that arrives during non-maskable service is held and served at the first boundary after the return.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `ien` is 0, `ack_req` is 0, `svc_start` is 0, and no non-maskable request is pending or in service.
- R2: No service starts and `ack_req` does not rise in any cycle that does not follow a cycle with `insn_boundary` high.
- R3: A maskable request is taken at a boundary only when `mreq` is high and `ien` is 1. `ack_req` rises in the cycle after that boundary.
- R4: `ack_req` stays high until `ack_valid` is seen. The vector on `ack_vector` is captured at that edge. In the next cycle `svc_start` is 1 with that vector and `svc_is_nmi` is 0, and `ack_req` is 0.
- R5: A pending non-maskable request is taken at a boundary with no handshake. In the next cycle `svc_start` is 1, `svc_vector` is 8'h02 and `svc_is_nmi` is 1.
- R6: When both requests are eligible at one boundary, the non-maskable one starts first. The maskable one is taken at a later boundary only if `ien` has been set to 1 again.
- R7: `ien` reads 0 in the cycle `svc_start` is high. An `irq_return` restores the value `ien` held just before that service began.
- R8: `nmi_in` is rising-edge detected one cycle before it can be taken. A level held high produces exactly one service.
- R9: While non-maskable service is active, no further non-maskable service starts until `irq_return`. Any number of rising edges during that window leave exactly one request, which is served at the first boundary after the return.
- R10: `flag_wr` loads `flag_wdata` into `ien`, visible in the next cycle, unless a service entry or a return takes priority in that cycle.
- R11: Saved flag values are restored in last-in, first-out order across nested services, up to `NEST_DEPTH` levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mreq | input | 1 | Maskable request level |
| nmi_in | input | 1 | Non-maskable request, edge detected |
| insn_boundary | input | 1 | Core is between instructions this cycle |
| irq_return | input | 1 | Core executed an interrupt return |
| flag_wr | input | 1 | Write strobe for the enable flag |
| flag_wdata | input | 1 | Value written to the enable flag |
| ack_req | output | 1 | Vector acknowledge request |
| ack_valid | input | 1 | Vector acknowledge response |
| ack_vector | input | 8 | Vector returned with `ack_valid` |
| svc_start | output | 1 | One-cycle start-of-service pulse |
| svc_vector | output | 8 | Vector of the service starting |
| svc_is_nmi | output | 1 | Service is non-maskable |
| ien | output | 1 | Current interrupt-enable flag |

## Verification
A stale pending latch or a stuck in-service bit shows up at the first boundary after a return: a non-maskable start is either missing or duplicated in the very next cycle. A corrupted save stack is visible on `ien` one cycle after each `irq_return`, so nested entries with differing flag values expose ordering errors immediately. A wrong handshake state shows as `ack_req` dropping early or `svc_start` carrying a vector other than the one offered on the acknowledging edge.

// File: rtl/irq_pkg.sv
// Shared constants and types for the interrupt arbiter.
package irq_pkg;
    localparam int VEC_W = 8;
    localparam logic [VEC_W-1:0] NMI_VECTOR = 8'h02;

    typedef enum logic [0:0] {
        ARB_IDLE = 1'b0,
        ARB_ACK  = 1'b1
    } arb_state_e;
endpackage

// File: rtl/irq_nmi_track.sv
// Non-maskable request tracking: rising-edge detect, a one-deep pending
// latch and the in-service state. Assumes take_nmi is only raised while
// nmi_ready is high.
module irq_nmi_track (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic take_nmi,
    input  logic ret,
    output logic nmi_ready,
    output logic nmi_active
);
    logic nmi_q;
    logic nmi_pend;
    logic nmi_rise;

    assign nmi_rise  = nmi_in & ~nmi_q;
    assign nmi_ready = nmi_pend & ~nmi_active;

    // Edge history, pending latch and in-service flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q      <= 1'b0;
            nmi_pend   <= 1'b0;
            nmi_active <= 1'b0;
        end else begin
            nmi_q    <= nmi_in;
            nmi_pend <= nmi_rise | (nmi_pend & ~take_nmi);
            if (take_nmi)
                nmi_active <= 1'b1;
            else if (ret)
                nmi_active <= 1'b0;
        end
    end

    // R9: a pending request survives until it is taken.
    a_r9_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend && !take_nmi |=> nmi_pend);
    // R9: no re-entry while non-maskable service is active.
    a_r9_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_active |-> !take_nmi);
endmodule

// File: rtl/irq_flag_stack.sv
// Interrupt-enable flag with a save stack of NEST_DEPTH entries.
// Entry pushes the flag and clears it; return pops it. A push when the
// stack is full drops the deepest entry. A pop on an empty stack leaves
// the flag alone.
module irq_flag_stack #(
    parameter int NEST_DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic ret,
    input  logic wr,
    input  logic wdata,
    output logic ien
);
    localparam int CNT_W = $clog2(NEST_DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NEST_DEPTH);

    logic [NEST_DEPTH-1:0] stk;
    logic [CNT_W-1:0]      cnt;

    // Flag update with priority entry > return > software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= 1'b0;
            stk <= '0;
            cnt <= '0;
        end else if (enter) begin
            ien <= 1'b0;
            stk <= {stk[NEST_DEPTH-2:0], ien};
            if (cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
        end else if (ret) begin
            if (cnt != '0) begin
                ien <= stk[0];
                stk <= {1'b0, stk[NEST_DEPTH-1:1]};
                cnt <= cnt - 1'b1;
            end
        end else if (wr) begin
            ien <= wdata;
        end
    end

    // R11: the stack depth never exceeds its capacity.
    a_r11_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);
endmodule

// File: rtl/irq_ack_fsm.sv
// Boundary decision and vector handshake. At a boundary a ready
// non-maskable request wins; otherwise an enabled maskable request
// starts the acknowledge handshake. Boundaries are ignored while the
// handshake is in flight.
module irq_ack_fsm
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             mreq,
    input  logic             ien,
    input  logic             nmi_ready,
    input  logic             ack_valid,
    input  logic [VEC_W-1:0] ack_vector,
    output logic             ack_req,
    output logic             take_nmi,
    output logic             take_irq,
    output logic             svc_start,
    output logic [VEC_W-1:0] svc_vector,
    output logic             svc_is_nmi
);
    arb_state_e state;
    logic       go_ack;

    assign take_nmi = (state == ARB_IDLE) & boundary & nmi_ready;
    assign go_ack   = (state == ARB_IDLE) & boundary & ~nmi_ready & mreq & ien;
    assign take_irq = (state == ARB_ACK) & ack_valid;
    assign ack_req  = (state == ARB_ACK);

    // Handshake state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ARB_IDLE;
        else if (go_ack)
            state <= ARB_ACK;
        else if (take_irq)
            state <= ARB_IDLE;
    end

    // Start pulse and vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_start  <= 1'b0;
            svc_vector <= '0;
            svc_is_nmi <= 1'b0;
        end else begin
            svc_start <= take_nmi | take_irq;
            if (take_nmi) begin
                svc_vector <= NMI_VECTOR;
                svc_is_nmi <= 1'b1;
            end else if (take_irq) begin
                svc_vector <= ack_vector;
                svc_is_nmi <= 1'b0;
            end
        end
    end

    // R4: the request is held until acknowledged.
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req && !ack_valid |=> ack_req);
    // R4: a maskable start follows an acknowledge edge.
    a_r4_start_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        svc_start && !svc_is_nmi |-> $past(ack_req && ack_valid));
    // R5: non-maskable starts carry the fixed vector.
    a_r5_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        svc_start && svc_is_nmi |-> svc_vector == NMI_VECTOR);
    // R2: the handshake only opens after a boundary.
    a_r2_ack_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) |-> $past(boundary));
endmodule

// File: rtl/irq_arbiter.sv
// Top level of the external interrupt arbiter. Connects the non-maskable
// tracker, the enable-flag save stack and the boundary/handshake
// controller. Assumes insn_boundary and irq_return are single-cycle
// strobes from the core.
module irq_arbiter #(
    parameter int NEST_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mreq,
    input  logic       nmi_in,
    input  logic       insn_boundary,
    input  logic       irq_return,
    input  logic       flag_wr,
    input  logic       flag_wdata,
    output logic       ack_req,
    input  logic       ack_valid,
    input  logic [7:0] ack_vector,
    output logic       svc_start,
    output logic [7:0] svc_vector,
    output logic       svc_is_nmi,
    output logic       ien
);
    logic nmi_ready;
    logic nmi_active;
    logic take_nmi;
    logic take_irq;

    irq_nmi_track u_nmi (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_in     (nmi_in),
        .take_nmi   (take_nmi),
        .ret        (irq_return),
        .nmi_ready  (nmi_ready),
        .nmi_active (nmi_active)
    );

    irq_flag_stack #(.NEST_DEPTH(NEST_DEPTH)) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .enter (take_nmi | take_irq),
        .ret   (irq_return),
        .wr    (flag_wr),
        .wdata (flag_wdata),
        .ien   (ien)
    );

    irq_ack_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (insn_boundary),
        .mreq       (mreq),
        .ien        (ien),
        .nmi_ready  (nmi_ready),
        .ack_valid  (ack_valid),
        .ack_vector (ack_vector),
        .ack_req    (ack_req),
        .take_nmi   (take_nmi),
        .take_irq   (take_irq),
        .svc_start  (svc_start),
        .svc_vector (svc_vector),
        .svc_is_nmi (svc_is_nmi)
    );

    // R7: the enable flag is already clear when service starts.
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        svc_start |-> !ien);
    // R9: a non-maskable start marks service active.
    a_r9_active_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        svc_start && svc_is_nmi |-> nmi_active);
    // R2: a non-maskable start follows a boundary.
    a_r2_nmi_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        svc_start && svc_is_nmi |-> $past(insn_boundary));
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mreq = 1'b0, nmi_in = 1'b0, insn_boundary = 1'b0, irq_return = 1'b0;
    logic       flag_wr = 1'b0, flag_wdata = 1'b0, ack_valid = 1'b0;
    logic [7:0] ack_vector = 8'h00;
    logic       ack_req, svc_start, svc_is_nmi, ien;
    logic [7:0] svc_vector;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    irq_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .mreq(mreq), .nmi_in(nmi_in),
        .insn_boundary(insn_boundary), .irq_return(irq_return),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .ack_req(ack_req),
        .ack_valid(ack_valid), .ack_vector(ack_vector), .svc_start(svc_start),
        .svc_vector(svc_vector), .svc_is_nmi(svc_is_nmi), .ien(ien)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic boundary();
        insn_boundary = 1'b1; tick(); insn_boundary = 1'b0;
    endtask

    task automatic do_return();
        irq_return = 1'b1; tick(); irq_return = 1'b0;
    endtask

    task automatic write_flag(input bit v);
        flag_wr = 1'b1; flag_wdata = v; tick(); flag_wr = 1'b0;
    endtask

    task automatic nmi_pulse();
        nmi_in = 1'b1; tick(); nmi_in = 1'b0; tick();
    endtask

    task automatic expect_nmi_start(input string req);
        chk_eq(req, "svc_start", svc_start, 1);
        chk_eq(req, "svc_is_nmi", svc_is_nmi, 1);
        chk_eq(req, "svc_vector", svc_vector, 8'h02);
        chk_eq(req, "ack_req", ack_req, 0);
    endtask

    task automatic ack_with(input logic [7:0] v, input string req);
        ack_valid = 1'b1; ack_vector = v; tick(); ack_valid = 1'b0;
        chk_eq(req, "svc_start", svc_start, 1);
        chk_eq(req, "svc_vector", svc_vector, v);
        chk_eq(req, "svc_is_nmi", svc_is_nmi, 0);
        chk_eq(req, "ack_req dropped", ack_req, 0);
    endtask

    task automatic t_reset();
        chk_eq("R1", "ien", ien, 0);
        chk_eq("R1", "ack_req", ack_req, 0);
        chk_eq("R1", "svc_start", svc_start, 0);
        boundary();
        chk_eq("R1", "no nmi pending", svc_start, 0);
    endtask

    task automatic t_masked();
        mreq = 1'b1; boundary();
        chk_eq("R3", "ack_req with ien=0", ack_req, 0);
        mreq = 1'b0;
    endtask

    task automatic t_no_boundary();
        write_flag(1'b1);
        chk_eq("R10", "ien after write", ien, 1);
        mreq = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk_eq("R2", "ack_req without boundary", ack_req, 0);
            chk_eq("R2", "svc_start without boundary", svc_start, 0);
        end
    endtask

    task automatic t_maskable();
        boundary();
        chk_eq("R3", "ack_req after boundary", ack_req, 1);
        chk_eq("R3", "svc_start before ack", svc_start, 0);
        for (int i = 0; i < 2; i++) begin
            boundary();
            chk_eq("R4", "ack_req held", ack_req, 1);
        end
        ack_with(8'h5A, "R4");
        chk_eq("R7", "ien at start", ien, 0);
        mreq = 1'b0; tick();
        chk_eq("R4", "single pulse", svc_start, 0);
        do_return();
        chk_eq("R7", "ien restored", ien, 1);
    endtask

    task automatic t_nmi_level();
        nmi_in = 1'b1; tick();
        boundary();
        expect_nmi_start("R5");
        chk_eq("R7", "ien at nmi start", ien, 0);
        do_return();
        chk_eq("R7", "ien after nmi return", ien, 1);
        boundary();
        chk_eq("R8", "held level no second start", svc_start, 0);
        nmi_in = 1'b0; tick();
    endtask

    task automatic t_nmi_block();
        nmi_pulse(); boundary();
        expect_nmi_start("R9");
        nmi_pulse(); nmi_pulse();
        boundary();
        chk_eq("R9", "blocked while active", svc_start, 0);
        do_return();
        boundary();
        expect_nmi_start("R9");
        do_return();
        boundary();
        chk_eq("R9", "only one latched", svc_start, 0);
        chk_eq("R7", "ien after two returns", ien, 1);
    endtask

    task automatic t_priority();
        mreq = 1'b1; nmi_pulse();
        boundary();
        expect_nmi_start("R6");
        boundary();
        chk_eq("R6", "maskable held off by ien=0", ack_req, 0);
        write_flag(1'b1);
        boundary();
        chk_eq("R6", "maskable after re-enable", ack_req, 1);
        ack_with(8'h21, "R6");
        mreq = 1'b0;
        do_return();
        chk_eq("R11", "inner restore", ien, 1);
        do_return();
        chk_eq("R11", "outer restore", ien, 1);
    endtask

    task automatic t_nesting();
        mreq = 1'b1; boundary();
        chk_eq("R11", "ack_req", ack_req, 1);
        ack_with(8'h40, "R11");
        mreq = 1'b0;
        nmi_pulse(); boundary();
        expect_nmi_start("R11");
        do_return();
        chk_eq("R11", "lifo first pop", ien, 0);
        do_return();
        chk_eq("R11", "lifo second pop", ien, 1);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_masked();
        t_no_boundary();
        t_maskable();
        t_nmi_level();
        t_nmi_block();
        t_priority();
        t_nesting();
        tick();
        finish_run();
    end
endmodule